// File: doc/BRIEF.md
# Data-Space Register File with Index Pointer Pairs

This block holds the working state of a small 8-bit processor core: thirty-two general registers, an I/O register bank and an internal SRAM. All of them can be reached through one linear 16-bit data address. The execution unit reads two registers at once and writes one back on each clock. The load/store path reaches the same registers, plus the I/O bank and the SRAM, by address. The top six registers also form three 16-bit index pointers. A separate pointer port reads or writes each pointer as one word.

The address map has four regions. General register n sits at address n (0x00 to 0x1F). The 64 low I/O registers sit at 0x20 to 0x5F. The 160 extended I/O registers sit at 0x60 to 0xFF. The 2048-byte SRAM spans 0x0100 to 0x08FF. Single-bit set and clear requests may target only the first 32 I/O registers. A request anywhere else is dropped and reported with a one-cycle error pulse.

Every port accepts a request on every cycle. No port can apply back-pressure, so no handshake pins exist. All reads are combinational and all writes land on the next rising edge. A read in the same cycle as a write to the same location sees the old value.

Top module: `dspace_regfile`

## Requirements
- R1: The two register read ports return the selected general register combinationally. An execution-unit write lands at the next rising edge. A read of the same register in the write cycle returns the old value. All general registers reset to 0x00.
- R2: Bus address n in 0x00..0x1F reads and writes general register n. It is the same storage that the read ports and the execution-unit write port see.
- R3: Pointer select 0 maps to registers 26/27, select 1 to 28/29 and select 2 to 30/31. The even register holds bits 7:0 and the odd register holds bits 15:8. A pointer write updates both bytes at one edge. Select 3 reads 0x0000, and a write with select 3 changes nothing.
- R4: Bus addresses 0x20..0x5F reach 64 distinct I/O registers and 0x60..0xFF reach 160 distinct extended I/O registers. All of them reset to 0x00.
- R5: Bus addresses 0x0100..0x08FF reach 2048 distinct SRAM bytes. Addresses 0x0900 and above read as 0x00. Writes to them change no storage.
- R6: A bit request (bit_en=1) at an address in 0x20..0x3F changes only bit bit_pos of that register at the next edge. bit_val=1 sets the bit and bit_val=0 clears it.
- R7: A bit request at any address outside 0x20..0x3F changes no storage. bit_err is 1 for exactly the cycle after the request and 0 otherwise.
- R8: When several ports write the same location in one cycle, only one write lands. For a general register the pointer write beats the bus write, and the bus write beats the execution-unit write. For an I/O register the bus write beats the bit request.
- R9: Writes from different ports to different locations in the same cycle all land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_sel | input | 5 | Register number for read port A |
| rd_a_data | output | 8 | Read port A data |
| rd_b_sel | input | 5 | Register number for read port B |
| rd_b_data | output | 8 | Read port B data |
| alu_we | input | 1 | Execution-unit write enable |
| alu_wsel | input | 5 | Execution-unit write register number |
| alu_wdata | input | 8 | Execution-unit write data |
| bus_addr | input | 16 | Data-space address for bus read and write |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data for bus_addr |
| bit_en | input | 1 | Single-bit request enable |
| bit_addr | input | 16 | Data-space address of the bit request |
| bit_pos | input | 3 | Bit position within the byte |
| bit_val | input | 1 | 1 sets, 0 clears |
| bit_err | output | 1 | Rejected bit request, one cycle late |
| ptr_sel | input | 2 | Pointer select (0, 1, 2; 3 is unused) |
| ptr_we | input | 1 | Pointer word write enable |
| ptr_wdata | input | 16 | Pointer write word |
| ptr_rdata | output | 16 | Pointer read word |

## Verification
The bench targets the places where two address spaces meet or overlap.

- **Register aliasing.** A design whose register numbers and data addresses did not share storage would return stale bytes on one of the two paths.
- **Pointer byte order.** A pointer word split with the bytes swapped would show up as reversed bytes.
- **Write bypass.** A design that forwarded a write into a same-cycle read would return the new value too early.
- **Address boundaries.** The bench probes 0x5F/0x60, 0x08FF/0x0900 and the 0x3F/0x40 limit for bit requests. An SRAM index truncated without a range check would let a write to 0x0900 overwrite 0x0100.
- **Write collisions.** Same-cycle collisions on one location catch a wrong priority order.
- **Rejected bit requests.** A misplaced error pulse, or a bit change that leaks into a register, marks a faulty range check.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  // Region that a data-space address falls into
  typedef enum logic [2:0] {
    RG_GPR  = 3'd0,
    RG_IO   = 3'd1,
    RG_EXT  = 3'd2,
    RG_SRAM = 3'd3,
    RG_NONE = 3'd4
  } region_e;

endpackage

// File: rtl/dsr_decode.sv
module dsr_decode
  import dsr_pkg::*;
#(
  parameter int AW         = 16,
  parameter int NUM_GPR    = 32,
  parameter int IO_BASE    = 32,
  parameter int EXT_BASE   = 96,
  parameter int SRAM_BASE  = 256,
  parameter int SRAM_BYTES = 2048,
  localparam int GIW       = $clog2(NUM_GPR),
  localparam int OIW       = $clog2(SRAM_BASE - IO_BASE),
  localparam int SIW       = $clog2(SRAM_BYTES)
) (
  input  logic [AW-1:0]  addr,
  output region_e        region,
  output logic [GIW-1:0] gpr_idx,
  output logic [OIW-1:0] io_off,
  output logic [SIW-1:0] sram_off
);

  localparam logic [AW-1:0] L_IO   = IO_BASE[AW-1:0];
  localparam logic [AW-1:0] L_EXT  = EXT_BASE[AW-1:0];
  localparam logic [AW-1:0] L_SRAM = SRAM_BASE[AW-1:0];
  localparam logic [AW-1:0] L_END  = AW'(SRAM_BASE + SRAM_BYTES);

  logic [AW-1:0] io_diff;
  logic [AW-1:0] sram_diff;

  assign io_diff   = addr - L_IO;
  assign sram_diff = addr - L_SRAM;
  assign gpr_idx   = GIW'(addr);
  assign io_off    = OIW'(io_diff);
  assign sram_off  = SIW'(sram_diff);

  always_comb begin
    if (addr < L_IO)        region = RG_GPR;
    else if (addr < L_EXT)  region = RG_IO;
    else if (addr < L_SRAM) region = RG_EXT;
    else if (addr < L_END)  region = RG_SRAM;
    else                    region = RG_NONE;
  end

endmodule

// File: rtl/dsr_gpr.sv
module dsr_gpr #(
  parameter int DW       = 8,
  parameter int NUM      = 32,
  parameter int PTR_BASE = 26,
  localparam int IW      = $clog2(NUM),
  localparam int NPTR    = (NUM - PTR_BASE) / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_sel,
  output logic [DW-1:0] rd_a,
  input  logic [IW-1:0] rd_b_sel,
  output logic [DW-1:0] rd_b,
  input  logic [IW-1:0] bus_idx,
  output logic [DW-1:0] bus_rd,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wd,
  input  logic          alu_we,
  input  logic [IW-1:0] alu_sel,
  input  logic [DW-1:0] alu_wd,
  input  logic [1:0]    ptr_sel,
  input  logic          ptr_we,
  input  logic [2*DW-1:0] ptr_wd,
  output logic [2*DW-1:0] ptr_rd
);

  logic [DW-1:0] regs [NUM];
  logic          ptr_ok;
  logic [IW-1:0] ptr_lo;
  logic [IW-1:0] ptr_hi;

  assign ptr_ok = (32'(ptr_sel) < NPTR);
  assign ptr_lo = IW'(PTR_BASE) + IW'({ptr_sel, 1'b0});
  assign ptr_hi = ptr_lo | IW'(1);

  // Per-register write port arbitration: pointer, then bus, then ALU
  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (ptr_we && ptr_ok && ptr_lo == IW'(g)) begin
        regs[g] <= ptr_wd[DW-1:0];
      end else if (ptr_we && ptr_ok && ptr_hi == IW'(g)) begin
        regs[g] <= ptr_wd[2*DW-1:DW];
      end else if (bus_we && bus_idx == IW'(g)) begin
        regs[g] <= bus_wd;
      end else if (alu_we && alu_sel == IW'(g)) begin
        regs[g] <= alu_wd;
      end
    end
  end

  assign rd_a   = regs[rd_a_sel];
  assign rd_b   = regs[rd_b_sel];
  assign bus_rd = regs[bus_idx];
  assign ptr_rd = ptr_ok ? {regs[ptr_hi], regs[ptr_lo]} : '0;

endmodule

// File: rtl/dsr_iobank.sv
module dsr_iobank #(
  parameter int DW  = 8,
  parameter int NUM = 224,
  localparam int OIW = $clog2(NUM),
  localparam int BW  = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [OIW-1:0] idx,
  input  logic [DW-1:0]  wd,
  output logic [DW-1:0]  rd,
  input  logic           bit_we,
  input  logic [OIW-1:0] bit_idx,
  input  logic [BW-1:0]  bit_pos,
  input  logic           bit_val
);

  logic [DW-1:0] regs [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_io
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (we && idx == OIW'(g)) begin
        regs[g] <= wd;
      end else if (bit_we && bit_idx == OIW'(g)) begin
        regs[g][bit_pos] <= bit_val;
      end
    end
  end

  assign rd = (32'(idx) < NUM) ? regs[idx] : '0;

endmodule

// File: rtl/dsr_sram.sv
module dsr_sram #(
  parameter int DW    = 8,
  parameter int BYTES = 2048,
  localparam int SIW  = $clog2(BYTES)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [SIW-1:0] idx,
  input  logic [DW-1:0]  wd,
  output logic [DW-1:0]  rd
);

  logic [DW-1:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
  end

  assign rd = mem[idx];

endmodule

// File: rtl/dspace_regfile.sv
module dspace_regfile
  import dsr_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int NUM_GPR    = 32,
  parameter int PTR_BASE   = 26,
  parameter int NUM_IO     = 64,
  parameter int EXT_END    = 256,
  parameter int SRAM_BYTES = 2048,
  parameter int BIT_IO_CNT = 32,
  localparam int IO_BASE   = NUM_GPR,
  localparam int EXT_BASE  = IO_BASE + NUM_IO,
  localparam int SRAM_BASE = EXT_END,
  localparam int IO_TOTAL  = EXT_END - IO_BASE,
  localparam int GIW       = $clog2(NUM_GPR),
  localparam int OIW       = $clog2(IO_TOTAL),
  localparam int SIW       = $clog2(SRAM_BYTES),
  localparam int BW        = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [GIW-1:0]  rd_a_sel,
  output logic [DW-1:0]   rd_a_data,
  input  logic [GIW-1:0]  rd_b_sel,
  output logic [DW-1:0]   rd_b_data,
  input  logic            alu_we,
  input  logic [GIW-1:0]  alu_wsel,
  input  logic [DW-1:0]   alu_wdata,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            bit_en,
  input  logic [AW-1:0]   bit_addr,
  input  logic [BW-1:0]   bit_pos,
  input  logic            bit_val,
  output logic            bit_err,
  input  logic [1:0]      ptr_sel,
  input  logic            ptr_we,
  input  logic [2*DW-1:0] ptr_wdata,
  output logic [2*DW-1:0] ptr_rdata
);

  region_e        bus_rg, bit_rg;
  logic [GIW-1:0] bus_gidx, bit_gidx;
  logic [OIW-1:0] bus_ioff, bit_ioff;
  logic [SIW-1:0] bus_soff, bit_soff;
  logic [DW-1:0]  gpr_rd, io_rd, sram_rd;
  logic           bit_ok;
  logic           bus_is_io;

  // One decoder for the bus address, one for the bit request address
  dsr_decode #(
    .AW(AW), .NUM_GPR(NUM_GPR), .IO_BASE(IO_BASE), .EXT_BASE(EXT_BASE),
    .SRAM_BASE(SRAM_BASE), .SRAM_BYTES(SRAM_BYTES)
  ) u_dec_bus (
    .addr(bus_addr), .region(bus_rg), .gpr_idx(bus_gidx),
    .io_off(bus_ioff), .sram_off(bus_soff)
  );

  dsr_decode #(
    .AW(AW), .NUM_GPR(NUM_GPR), .IO_BASE(IO_BASE), .EXT_BASE(EXT_BASE),
    .SRAM_BASE(SRAM_BASE), .SRAM_BYTES(SRAM_BYTES)
  ) u_dec_bit (
    .addr(bit_addr), .region(bit_rg), .gpr_idx(bit_gidx),
    .io_off(bit_ioff), .sram_off(bit_soff)
  );

  assign bus_is_io = (bus_rg == RG_IO) || (bus_rg == RG_EXT);
  assign bit_ok    = bit_en && (bit_rg == RG_IO) && (32'(bit_ioff) < BIT_IO_CNT);

  dsr_gpr #(.DW(DW), .NUM(NUM_GPR), .PTR_BASE(PTR_BASE)) u_gpr (
    .clk(clk), .rst_n(rst_n),
    .rd_a_sel(rd_a_sel), .rd_a(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b(rd_b_data),
    .bus_idx(bus_gidx), .bus_rd(gpr_rd),
    .bus_we(bus_we && bus_rg == RG_GPR), .bus_wd(bus_wdata),
    .alu_we(alu_we), .alu_sel(alu_wsel), .alu_wd(alu_wdata),
    .ptr_sel(ptr_sel), .ptr_we(ptr_we), .ptr_wd(ptr_wdata), .ptr_rd(ptr_rdata)
  );

  dsr_iobank #(.DW(DW), .NUM(IO_TOTAL)) u_io (
    .clk(clk), .rst_n(rst_n),
    .we(bus_we && bus_is_io), .idx(bus_ioff), .wd(bus_wdata), .rd(io_rd),
    .bit_we(bit_ok), .bit_idx(bit_ioff), .bit_pos(bit_pos), .bit_val(bit_val)
  );

  dsr_sram #(.DW(DW), .BYTES(SRAM_BYTES)) u_sram (
    .clk(clk), .we(bus_we && bus_rg == RG_SRAM), .idx(bus_soff),
    .wd(bus_wdata), .rd(sram_rd)
  );

  always_comb begin
    unique case (bus_rg)
      RG_GPR:         bus_rdata = gpr_rd;
      RG_IO, RG_EXT:  bus_rdata = io_rd;
      RG_SRAM:        bus_rdata = sram_rd;
      default:        bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bit_err <= 1'b0;
    else        bit_err <= bit_en && !bit_ok;
  end

endmodule

// File: rtl/dsr_checker.sv
module dsr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  rd_a_sel,
  input logic [7:0]  rd_a_data,
  input logic [4:0]  rd_b_sel,
  input logic [7:0]  rd_b_data,
  input logic        alu_we,
  input logic [4:0]  alu_wsel,
  input logic [7:0]  alu_wdata,
  input logic [15:0] bus_addr,
  input logic        bus_we,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        bit_en,
  input logic [15:0] bit_addr,
  input logic [2:0]  bit_pos,
  input logic        bit_val,
  input logic        bit_err,
  input logic [1:0]  ptr_sel,
  input logic        ptr_we,
  input logic [15:0] ptr_wdata,
  input logic [15:0] ptr_rdata
);

  logic bit_in_range;
  assign bit_in_range = (bit_addr >= 16'h0020) && (bit_addr <= 16'h003F);

  // R1: an uncontested execution-unit write is visible on read port B
  a_r1_alu_write: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && !ptr_we && !(bus_we && bus_addr < 16'h0020))
    |=> (rd_b_sel != $past(alu_wsel) || rd_b_data == $past(alu_wdata)));

  // R2: bus view of a register equals the register read port
  a_r2_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < 16'h0020 && rd_a_sel == bus_addr[4:0]) |-> bus_rdata == rd_a_data);

  // R3: a valid pointer write reads back as the same word
  a_r3_ptr_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_sel != 2'd3)
    |=> (ptr_sel != $past(ptr_sel) || ptr_rdata == $past(ptr_wdata)));

  // R3: unused pointer select reads zero
  a_r3_sel3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel == 2'd3) |-> ptr_rdata == 16'h0000);

  // R5: addresses past the SRAM read zero
  a_r5_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= 16'h0900) |-> bus_rdata == 8'h00);

  // R7: out-of-range bit request flags an error next cycle
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !bit_in_range) |=> bit_err);

  // R7: no error without an out-of-range request
  a_r7_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && !bit_in_range) |=> !bit_err);

  // R8: pointer write beats execution-unit write on X low byte
  a_r8_ptr_over_alu: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_sel == 2'd0 && alu_we && alu_wsel == 5'd26)
    |=> (rd_a_sel != 5'd26 || rd_a_data == $past(ptr_wdata[7:0])));

endmodule

bind dspace_regfile dsr_checker u_chk (.*);

// File: tb/tb_dspace_regfile.sv
module tb_dspace_regfile;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_a_sel, rd_b_sel, alu_wsel;
  logic [7:0]  rd_a_data, rd_b_data, alu_wdata, bus_wdata, bus_rdata;
  logic        alu_we, bus_we, bit_en, bit_val, bit_err, ptr_we;
  logic [15:0] bus_addr, bit_addr, ptr_wdata, ptr_rdata;
  logic [2:0]  bit_pos;
  logic [1:0]  ptr_sel;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  dspace_regfile dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_we = 0; bus_we = 0; bit_en = 0; ptr_we = 0;
    alu_wsel = 0; alu_wdata = 0; bus_wdata = 0; bit_val = 0; bit_pos = 0;
    bit_addr = 16'h0020; bus_addr = 16'h0000; ptr_sel = 0; ptr_wdata = 0;
    rd_a_sel = 0; rd_b_sel = 0;
  endtask

  // Advance one clock; returns 1 time unit after the rising edge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    idle(); bus_addr = a; bus_wdata = d; bus_we = 1; tick(); idle();
  endtask

  task automatic bus_chk(input string req, input logic [15:0] a, input logic [7:0] e);
    bus_addr = a; #1; chk(req, bus_rdata, e);
  endtask

  task automatic t_reset();
    chk("R1 reset r0", rd_a_data, 0);
    rd_b_sel = 31; #1; chk("R1 reset r31", rd_b_data, 0);
    bus_chk("R4 reset io", 16'h0020, 0);
    bus_chk("R4 reset ext", 16'h00FF, 0);
    ptr_sel = 2; #1; chk("R3 reset ptr", ptr_rdata, 0);
    chk("R7 reset err", bit_err, 0);
    idle();
  endtask

  task automatic t_alu();
    idle(); alu_we = 1; alu_wsel = 5; alu_wdata = 8'hA5; rd_a_sel = 5; #1;
    chk("R1 no bypass", rd_a_data, 0);
    tick(); idle(); rd_a_sel = 5; rd_b_sel = 5; #1;
    chk("R1 read A", rd_a_data, 8'hA5);
    chk("R1 read B", rd_b_data, 8'hA5);
    alu_we = 1; alu_wsel = 31; alu_wdata = 8'h3C; tick(); idle();
    rd_b_sel = 31; #1; chk("R1 write r31", rd_b_data, 8'h3C);
  endtask

  task automatic t_alias();
    bus_wr(16'h0007, 8'h6B);
    rd_a_sel = 7; #1; chk("R2 bus to port", rd_a_data, 8'h6B);
    alu_we = 1; alu_wsel = 9; alu_wdata = 8'h5A; tick(); idle();
    bus_chk("R2 port to bus", 16'h0009, 8'h5A);
  endtask

  task automatic t_pointer();
    idle(); ptr_sel = 1; ptr_we = 1; ptr_wdata = 16'hBEEF; tick(); idle();
    rd_a_sel = 28; rd_b_sel = 29; #1;
    chk("R3 Y low byte", rd_a_data, 8'hEF);
    chk("R3 Y high byte", rd_b_data, 8'hBE);
    ptr_sel = 1; #1; chk("R3 Y word", ptr_rdata, 16'hBEEF);
    alu_we = 1; alu_wsel = 30; alu_wdata = 8'h34; tick();
    alu_wsel = 31; alu_wdata = 8'h12; tick(); idle();
    ptr_sel = 2; #1; chk("R3 Z word", ptr_rdata, 16'h1234);
    ptr_sel = 3; ptr_we = 1; ptr_wdata = 16'hFFFF; #1;
    chk("R3 sel3 reads zero", ptr_rdata, 0);
    tick(); idle();
    ptr_sel = 0; #1; chk("R3 sel3 X untouched", ptr_rdata, 0);
    ptr_sel = 1; #1; chk("R3 sel3 Y untouched", ptr_rdata, 16'hBEEF);
    ptr_sel = 2; #1; chk("R3 sel3 Z untouched", ptr_rdata, 16'h1234);
  endtask

  task automatic t_io();
    bus_wr(16'h0020, 8'h11);
    bus_wr(16'h005F, 8'h22);
    bus_wr(16'h0060, 8'h33);
    bus_wr(16'h00FF, 8'h44);
    bus_chk("R4 io first", 16'h0020, 8'h11);
    bus_chk("R4 io last", 16'h005F, 8'h22);
    bus_chk("R4 ext first", 16'h0060, 8'h33);
    bus_chk("R4 ext last", 16'h00FF, 8'h44);
    bus_chk("R4 io other", 16'h0021, 8'h00);
  endtask

  task automatic t_sram();
    bus_wr(16'h0100, 8'h77);
    bus_wr(16'h08FF, 8'h88);
    bus_wr(16'h0900, 8'h99);
    bus_wr(16'h08FE, 8'h66);
    bus_chk("R5 sram first", 16'h0100, 8'h77);
    bus_chk("R5 sram last", 16'h08FF, 8'h88);
    bus_chk("R5 sram neighbour", 16'h08FE, 8'h66);
    bus_chk("R5 above end", 16'h0900, 8'h00);
    bus_chk("R5 top address", 16'hFFFF, 8'h00);
  endtask

  task automatic t_bitops();
    bus_wr(16'h0025, 8'h0F);
    bit_en = 1; bit_addr = 16'h0025; bit_pos = 7; bit_val = 1; tick(); idle();
    bus_chk("R6 set bit7", 16'h0025, 8'h8F);
    bit_en = 1; bit_addr = 16'h0025; bit_pos = 0; bit_val = 0; tick(); idle();
    bus_chk("R6 clear bit0", 16'h0025, 8'h8E);
    bit_en = 1; bit_addr = 16'h003F; bit_pos = 3; bit_val = 1; tick(); idle();
    bus_chk("R6 set at 0x3F", 16'h003F, 8'h08);
    chk("R7 no err in range", bit_err, 0);
  endtask

  task automatic t_bit_err();
    bus_wr(16'h0040, 8'hF0);
    bit_en = 1; bit_addr = 16'h0040; bit_pos = 0; bit_val = 1; tick(); idle();
    chk("R7 err pulse", bit_err, 1);
    bus_chk("R7 0x40 unchanged", 16'h0040, 8'hF0);
    tick();
    chk("R7 err one cycle", bit_err, 0);
    bus_wr(16'h0010, 8'h81);
    bit_en = 1; bit_addr = 16'h0010; bit_pos = 0; bit_val = 0; tick(); idle();
    chk("R7 err on register addr", bit_err, 1);
    rd_a_sel = 16; #1; chk("R7 r16 unchanged", rd_a_data, 8'h81);
  endtask

  task automatic t_priority();
    idle();
    ptr_we = 1; ptr_sel = 0; ptr_wdata = 16'h1234;
    alu_we = 1; alu_wsel = 26; alu_wdata = 8'hFF;
    bus_we = 1; bus_addr = 16'h001B; bus_wdata = 8'hEE;
    tick(); idle();
    rd_a_sel = 26; rd_b_sel = 27; #1;
    chk("R8 ptr beats alu", rd_a_data, 8'h34);
    chk("R8 ptr beats bus", rd_b_data, 8'h12);
    alu_we = 1; alu_wsel = 3; alu_wdata = 8'h55;
    bus_we = 1; bus_addr = 16'h0003; bus_wdata = 8'hAA; tick(); idle();
    rd_a_sel = 3; #1; chk("R8 bus beats alu", rd_a_data, 8'hAA);
    bus_wr(16'h0030, 8'h40);
    bus_we = 1; bus_addr = 16'h0030; bus_wdata = 8'h00;
    bit_en = 1; bit_addr = 16'h0030; bit_pos = 1; bit_val = 1; tick(); idle();
    bus_chk("R8 bus beats bit", 16'h0030, 8'h00);
    alu_we = 1; alu_wsel = 10; alu_wdata = 8'h10;
    bus_we = 1; bus_addr = 16'h000B; bus_wdata = 8'h20;
    ptr_we = 1; ptr_sel = 2; ptr_wdata = 16'hCAFE;
    bit_en = 1; bit_addr = 16'h0031; bit_pos = 2; bit_val = 1; tick(); idle();
    rd_a_sel = 10; rd_b_sel = 11; #1;
    chk("R9 alu lands", rd_a_data, 8'h10);
    chk("R9 bus lands", rd_b_data, 8'h20);
    ptr_sel = 2; #1; chk("R9 ptr lands", ptr_rdata, 16'hCAFE);
    bus_chk("R9 bit lands", 16'h0031, 8'h04);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    #1;
    t_reset();
    t_alu();
    t_alias();
    t_pointer();
    t_io();
    t_sram();
    t_bitops();
    t_bit_err();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule